// File: doc/BRIEF.md
# Memory Control Register with Refresh Timer

This block is a write-only control word for a processor's external bus interface. One write port loads a 32-bit value. The stored word is presented whole on `ctrl_word` for neighbouring logic. Its fields are also decoded onto dedicated outputs:

- output drive strength
- input threshold selection
- the active-low power-down control
- the memory type of region 0
- refresh test mode
- refresh rate
- the entry-table location
- one bus-hold break disable per region

Nothing can read the register back.

Inside the block, a refresh timer turns the 3-bit rate field into one-cycle refresh request pulses for the on-chip RAM. The interval is a power of two from 2 to 128 cycles. One code switches refresh off. The register comes out of reset with every bit set, so refresh starts switched off. A change of rate restarts the timer phase.

Reserved bit positions are held at one by the hardware whatever is written. A write that places a reserved code in the entry-table field is still stored as written, and the block flags it on an error output.

Top module: `mctl_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ctrl_word` is 32'hFFFF_FFFF. In that state `refresh_rate` is 3'b111, and `refresh_req` and `entry_code_err` are low.
- R2: Bits 31..26, 23, 19 and 15 of `ctrl_word` read one at all times, whatever value `wr_data` carries in those positions.
- R3: When `wr_en` is high at a clock edge, every non-reserved bit of `ctrl_word` takes the `wr_data` value from that edge onward. When `wr_en` is low, `ctrl_word` keeps its value whatever `wr_data` does.
- R4: Each decoded output follows one bit range of `ctrl_word`:
  - bit 25 drives `drive_rail`
  - bit 24 drives `thresh_5v`
  - bit 22 drives `cpu_run` (1 = running)
  - bit 21 drives `rgn0_non_dram`
  - bit 20 drives `refresh_normal`
  - bits 18..16 drive `refresh_rate`
  - bits 14..12 drive `entry_sel`
  - bit 8+i drives `hold_break_dis[i]` for region i = 0..3
- R5: While `refresh_rate` is 3'b111, `refresh_req` stays low.
- R6: With rate code c in 0..6 held steady, `refresh_req` is a one-cycle pulse with a period of N = 2^(7-c) cycles. Code 6 gives a 2-cycle period and code 0 gives 128 cycles.
- R7: A write that changes the rate field restarts the timer. The first request appears N cycles after the write edge, where N is the new interval. A write that leaves the rate field unchanged does not disturb the pulse phase.
- R8: A write whose bits 14..12 hold 3'b100, 3'b101 or 3'b110 still stores that code. `entry_code_err` is then high for exactly the one cycle after the write edge. Any other code, or no write, leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value to store |
| ctrl_word | output | 32 | Stored control word |
| drive_rail | output | 1 | 1 = full-swing outputs, 0 = reduced swing |
| thresh_5v | output | 1 | 1 = 5 V input threshold, 0 = 3.3 V |
| cpu_run | output | 1 | 1 = running, 0 = power-down requested |
| rgn0_non_dram | output | 1 | 1 = region 0 is not DRAM |
| refresh_normal | output | 1 | 1 = normal refresh, 0 = test mode |
| refresh_rate | output | 3 | Refresh rate code |
| entry_sel | output | 3 | Entry-table location code |
| hold_break_dis | output | 4 | Per-region bus-hold break disable |
| refresh_req | output | 1 | One-cycle refresh request pulse |
| entry_code_err | output | 1 | Reserved entry-table code was written |

## Verification
The bench walks every rate code. For each, it compares the exact cycle of every pulse with the arithmetic interval, so an off-by-one terminal count or a reversed code ladder shows up as shifted pulses. It then rewrites the rate in the middle of an interval, once with a new value and once with the same value. A timer that never restarts, or one that restarts on every write, puts the next pulse in the wrong cycle. It also writes every entry-table code to catch a missing or stretched error flag. Finally, it writes pseudo-random words, including all zeros, to expose reserved bits that can be cleared, decode taps on the wrong bit, and stores made while the strobe is low.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    localparam int WORD_W   = 32;
    localparam int RATE_W   = 3;
    localparam int ENTRY_W  = 3;
    localparam int REGIONS  = 4;

    // bit positions decoded by neighbouring logic
    localparam int POS_DRIVE  = 25;
    localparam int POS_THRESH = 24;
    localparam int POS_RUN    = 22;
    localparam int POS_R0TYPE = 21;
    localparam int POS_RFMODE = 20;
    localparam int RATE_LSB   = 16;
    localparam int ENTRY_LSB  = 12;
    localparam int BRK_LSB    = 8;

    // positions the hardware pins at one
    localparam logic [WORD_W-1:0] RSVD_MASK = 32'hFC88_8000;
    // positions that feed a decoded output
    localparam logic [WORD_W-1:0] USED_MASK = 32'h0377_7F00;

    // entry-table code for the internal RAM; codes above it, except all ones, are reserved
    localparam logic [ENTRY_W-1:0] ENTRY_IRAM = 3'b011;

    typedef struct packed {
        logic                 drive_rail;
        logic                 thresh_5v;
        logic                 cpu_run;
        logic                 rgn0_non_dram;
        logic                 refresh_normal;
        logic [RATE_W-1:0]    rate;
        logic [ENTRY_W-1:0]   entry;
        logic [REGIONS-1:0]   brk_dis;
    } mctl_fields_t;

    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] data);
        return (data & ~RSVD_MASK) | RSVD_MASK;
    endfunction

    function automatic logic entry_is_rsvd(input logic [ENTRY_W-1:0] code);
        return (code > ENTRY_IRAM) && (code != '1);
    endfunction

endpackage

// File: rtl/mctl_field_decode.sv
module mctl_field_decode
    import mctl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output mctl_fields_t      fields
);

    logic unused_bits;
    assign unused_bits = ^(word & ~USED_MASK);

    always_comb begin
        fields.drive_rail     = word[POS_DRIVE];
        fields.thresh_5v      = word[POS_THRESH];
        fields.cpu_run        = word[POS_RUN];
        fields.rgn0_non_dram  = word[POS_R0TYPE];
        fields.refresh_normal = word[POS_RFMODE];
        fields.rate           = word[RATE_LSB +: RATE_W];
        fields.entry          = word[ENTRY_LSB +: ENTRY_W];
        for (int i = 0; i < REGIONS; i++) begin
            fields.brk_dis[i] = word[BRK_LSB + i];
        end
    end

endmodule

// File: rtl/mctl_refresh_timer.sv
module mctl_refresh_timer #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    output logic              req
);

    localparam int                CNT_W    = (1 << RATE_W) - 1;
    localparam int                SPAN_W   = CNT_W + 1;
    localparam logic [RATE_W-1:0] OFF_CODE = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } tmr_t;

    tmr_t              tmr_d, tmr_q;
    logic [SPAN_W-1:0] span;
    logic [CNT_W-1:0]  term;

    // interval doubles for each step the code lies below the off code
    always_comb begin
        span = SPAN_W'(1) << (OFF_CODE - rate);
        term = CNT_W'(span - SPAN_W'(1));
    end

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.req = 1'b0;
        if (restart || rate == OFF_CODE) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == term) begin
            tmr_d.cnt = '0;
            tmr_d.req = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign req = tmr_q.req;

endmodule

// File: rtl/mctl_reg.sv
module mctl_reg
    import mctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    ctrl_word,
    output logic                 drive_rail,
    output logic                 thresh_5v,
    output logic                 cpu_run,
    output logic                 rgn0_non_dram,
    output logic                 refresh_normal,
    output logic [RATE_W-1:0]    refresh_rate,
    output logic [ENTRY_W-1:0]   entry_sel,
    output logic [REGIONS-1:0]   hold_break_dis,
    output logic                 refresh_req,
    output logic                 entry_code_err
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              err;
    } reg_t;

    reg_t          reg_d, reg_q;
    mctl_fields_t  fld;
    logic          rate_restart;

    always_comb begin
        reg_d        = reg_q;
        reg_d.err    = 1'b0;
        rate_restart = 1'b0;
        if (wr_en) begin
            reg_d.word   = merge_word(wr_data);
            reg_d.err    = entry_is_rsvd(wr_data[ENTRY_LSB +: ENTRY_W]);
            rate_restart = (wr_data[RATE_LSB +: RATE_W] != reg_q.word[RATE_LSB +: RATE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.word <= '1;
            reg_q.err  <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    mctl_field_decode u_dec (
        .word   (reg_q.word),
        .fields (fld)
    );

    mctl_refresh_timer #(
        .RATE_W (RATE_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (fld.rate),
        .restart (rate_restart),
        .req     (refresh_req)
    );

    assign ctrl_word      = reg_q.word;
    assign entry_code_err = reg_q.err;
    assign drive_rail     = fld.drive_rail;
    assign thresh_5v      = fld.thresh_5v;
    assign cpu_run        = fld.cpu_run;
    assign rgn0_non_dram  = fld.rgn0_non_dram;
    assign refresh_normal = fld.refresh_normal;
    assign refresh_rate   = fld.rate;
    assign entry_sel      = fld.entry;
    assign hold_break_dis = fld.brk_dis;

endmodule

// File: rtl/mctl_reg_chk.sv
module mctl_reg_chk
    import mctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [WORD_W-1:0]    ctrl_word,
    input logic [RATE_W-1:0]    refresh_rate,
    input logic [ENTRY_W-1:0]   entry_sel,
    input logic                 refresh_req,
    input logic                 entry_code_err
);

    AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_word & RSVD_MASK) == RSVD_MASK)); // R2

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_word & ~RSVD_MASK) == ($past(wr_data) & ~RSVD_MASK))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_word)); // R3

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_rate == '1) |=> !refresh_req); // R5

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req); // R6

    AST_RATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[RATE_LSB +: RATE_W] != refresh_rate)) |=> !refresh_req); // R7

    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && entry_is_rsvd(wr_data[ENTRY_LSB +: ENTRY_W])) |=> (entry_code_err && entry_is_rsvd(entry_sel))); // R8

    AST_ERR_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_code_err |-> $past(wr_en)); // R8

endmodule

bind mctl_reg mctl_reg_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .ctrl_word      (ctrl_word),
    .refresh_rate   (refresh_rate),
    .entry_sel      (entry_sel),
    .refresh_req    (refresh_req),
    .entry_code_err (entry_code_err)
);

// File: tb/mctl_reg_tb.sv
`timescale 1ns/1ps
module mctl_reg_tb;

    localparam logic [31:0] RSVD = 32'hFC88_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_word;
    logic        drive_rail, thresh_5v, cpu_run, rgn0_non_dram, refresh_normal;
    logic [2:0]  refresh_rate, entry_sel;
    logic [3:0]  hold_break_dis;
    logic        refresh_req, entry_code_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mctl_reg u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .ctrl_word      (ctrl_word),
        .drive_rail     (drive_rail),
        .thresh_5v      (thresh_5v),
        .cpu_run        (cpu_run),
        .rgn0_non_dram  (rgn0_non_dram),
        .refresh_normal (refresh_normal),
        .refresh_rate   (refresh_rate),
        .entry_sel      (entry_sel),
        .hold_break_dis (hold_break_dis),
        .refresh_req    (refresh_req),
        .entry_code_err (entry_code_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drives at a falling edge, returns at the falling edge after the write edge
    task automatic do_write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] with_rate(input logic [2:0] c);
        return (32'hFFFF_FFFF & ~(32'h7 << 16)) | (32'(c) << 16);
    endfunction

    task automatic check_fields(input logic [31:0] e, input string tag);
        chk(ctrl_word == e, tag, ctrl_word, e);
        chk({drive_rail, thresh_5v, cpu_run, rgn0_non_dram, refresh_normal} ==
            {e[25], e[24], e[22], e[21], e[20]}, "R4 flags",
            {27'd0, drive_rail, thresh_5v, cpu_run, rgn0_non_dram, refresh_normal},
            {27'd0, e[25], e[24], e[22], e[21], e[20]});
        chk({refresh_rate, entry_sel, hold_break_dis} == {e[18:16], e[14:12], e[11:8]}, "R4 fields",
            {22'd0, refresh_rate, entry_sel, hold_break_dis}, {22'd0, e[18:16], e[14:12], e[11:8]});
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        int bad;
        int first_j;
        lcg = 32'h1234_5678;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ctrl_word == 32'hFFFF_FFFF, "R1 during reset", ctrl_word, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_word == 32'hFFFF_FFFF, "R1 word", ctrl_word, 32'hFFFF_FFFF);
        chk(refresh_rate == 3'b111 && !refresh_req && !entry_code_err, "R1 rate/req/err",
            {29'd0, refresh_rate}, 32'd7);

        // R2 R3 R4 all-zero write keeps reserved ones
        do_write(32'h0000_0000);
        check_fields(RSVD, "R2 zero write");

        // R3 R4 pseudo-random words
        for (int k = 0; k < 24; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            do_write(lcg);
            check_fields((lcg & ~RSVD) | RSVD, "R3 random write");
        end

        // R3 idle: data toggles without strobe
        begin
            logic [31:0] held;
            held = ctrl_word;
            for (int k = 0; k < 4; k++) begin
                wr_data = ~held ^ (32'h1 << k);
                @(negedge clk);
                chk(ctrl_word == held, "R3 hold without wr_en", ctrl_word, held);
            end
        end

        // R5 off first, then R6 sweep of every enabled code
        do_write(with_rate(3'b111));
        bad = 0;
        for (int j = 0; j < 300; j++) begin
            if (refresh_req) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R5 disabled never requests", bad, 0);

        for (int c = 0; c < 7; c++) begin
            int n;
            n = 1 << (7 - c);
            do_write(with_rate(3'(c)));
            bad = 0;
            first_j = -1;
            for (int j = 0; j < 2 * n + 3; j++) begin
                bit exp;
                exp = (j > 0) && (j % n == 0);
                if (refresh_req !== exp) begin
                    bad++;
                    if (first_j < 0) first_j = j;
                end
                @(negedge clk);
            end
            chk(bad == 0, $sformatf("R6 code %0d period %0d (first bad cycle %0d)", c, n, first_j), bad, 0);
        end

        // R7 same-rate write keeps the phase
        do_write(with_rate(3'b111));
        do_write(with_rate(3'b100));
        bad = 0;
        for (int j = 0; j < 20; j++) begin
            if (refresh_req !== ((j > 0) && (j % 8 == 0))) bad++;
            if (j == 3) do_write(with_rate(3'b100) & ~32'h0200_0000);
            else @(negedge clk);
        end
        chk(bad == 0, "R7 unchanged rate keeps phase", bad, 0);

        // R7 changed rate restarts
        do_write(with_rate(3'b111));
        do_write(with_rate(3'b100));
        bad = 0;
        for (int j = 0; j < 3; j++) begin
            if (refresh_req) bad++;
            @(negedge clk);
        end
        do_write(with_rate(3'b011));
        for (int k = 0; k < 35; k++) begin
            if (refresh_req !== ((k > 0) && (k % 16 == 0))) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7 new rate restarts interval", bad, 0);

        // R8 every entry code
        for (int e = 0; e < 8; e++) begin
            logic [31:0] w;
            bit exp_err;
            w = (32'hFFFF_FFFF & ~(32'h7 << 12)) | (32'(e) << 12);
            exp_err = (e >= 4) && (e <= 6);
            do_write(w);
            chk(entry_code_err == exp_err, $sformatf("R8 flag code %0d", e), {31'd0, entry_code_err}, {31'd0, exp_err});
            chk(entry_sel == 3'(e), "R8 code stored", {29'd0, entry_sel}, 32'(e));
            @(negedge clk);
            chk(entry_code_err == 1'b0, "R8 flag one cycle", {31'd0, entry_code_err}, 32'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule